// File: doc/BRIEF.md
# DTMF Tone Pair Frequency Classifier

This block takes two 1-bit square waves from a signalling front end. One is the limited output of the low-band filter and the other is the limited output of the high-band filter. The block measures the period of each wave by counting system-clock cycles from one rising edge to the next. Each band keeps a running sum of its last four complete periods. That sum is compared against one acceptance window per nominal tone of the band. The windows are computed at elaboration from the clock rate and a tolerance in per-mille.

A band reports a match only while its sum lies inside one window. When both bands match in the same cycle, the early tone-pair flag is raised and the row and column indices name the key. A wave that stops toggling makes its period counter saturate. The saturated counter clears that band's history, so the band must collect four fresh periods before it can match again. Checking how long a tone lasts and latching the digit are left to a downstream stage.

All results are plain levels with no handshake. A consumer samples them on any cycle and cannot apply back-pressure. The inputs are treated as already synchronous to `clk`.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: A band matches only after four complete rising-edge-to-rising-edge periods have been measured since reset or since its last overflow. With two or fewer complete periods, its valid output stays low.
- R2: Low-band tones of 697, 770, 852 and 941 Hz give `row_idx` values 0, 1, 2 and 3 (binary) with `row_valid` high.
- R3: High-band tones of 1209, 1336, 1477 and 1633 Hz give `col_idx` values 0, 1, 2 and 3 (binary) with `col_valid` high.
- R4: A tone within ±1.4 % of its nominal frequency is accepted. The acceptance window is ±`TOL_PM`/1000 around the nominal, 2.5 % by default, which covers ±1.5 % ±2 Hz.
- R5: A tone 4 % above or 4 % below its nominal frequency matches no window, and that band's valid output stays low.
- R6: `pair_present` is high only in cycles where `row_valid` and `col_valid` are both high. The loss of either band drops it in the same cycle.
- R7: If a band sees no rising edge for longer than its overflow limit, its valid output falls. The limit is 9/8 of the longest accepted period of that band's slowest tone.
- R8: A synchronous active-high `rst` clears all counters and histories. In the cycle after `rst` is sampled, `row_valid`, `col_valid` and `pair_present` are low.
- R9: While a band is not valid, its index output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing reference clock. All counts are in cycles of this clock. |
| rst | input | 1 | Synchronous reset, active high. |
| lo_wave | input | 1 | Limited square wave from the low band. |
| hi_wave | input | 1 | Limited square wave from the high band. |
| row_valid | output | 1 | The low band matches a nominal tone. |
| col_valid | output | 1 | The high band matches a nominal tone. |
| pair_present | output | 1 | Early flag: both bands match in this cycle. |
| row_idx | output | 2 | Matched low-band tone index, 0 when not valid. |
| col_idx | output | 2 | Matched high-band tone index, 0 when not valid. |

## Verification
An overflow in one band and a freshly completed, in-window period in the other band can land in the same cycle. The bench provokes this by silencing the high input while the low tone keeps running. The run is judged correct when `pair_present` and `col_valid` have fallen and `row_valid` still holds its index. A reset is also applied while both tones are running. The bench then checks that the pending rising edge taken in during reset does not count toward the four periods: the row stays invalid until four new periods have been measured.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

  localparam int GRP_N = 4;
  localparam int IDX_W = 2;

  function automatic longint nom_hz(input bit hi, input int k);
    longint f;
    if (hi) begin
      case (k)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end else begin
      case (k)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end
    return f;
  endfunction

  // Smallest accepted sum of n periods (tone at upper frequency edge)
  function automatic longint win_lo(input longint clk_hz, input longint f,
                                    input longint tol_pm, input longint n);
    longint num;
    longint den;
    num = n * clk_hz * 1000;
    den = f * (1000 + tol_pm);
    return (num + den - 1) / den;
  endfunction

  // Largest accepted sum of n periods (tone at lower frequency edge)
  function automatic longint win_hi(input longint clk_hz, input longint f,
                                    input longint tol_pm, input longint n);
    return (n * clk_hz * 1000) / (f * (1000 - tol_pm));
  endfunction

  // Saturation limit of one period counter: slowest tone plus 1/8 margin
  function automatic longint ovf_cycles(input longint clk_hz, input bit hi,
                                        input longint tol_pm, input longint n);
    return ((win_hi(clk_hz, nom_hz(hi, 0), tol_pm, n) / n) * 9) / 8;
  endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int PER_W   = 13,
  parameter int OVF_LIM = 5925
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wave_i,
  output logic [PER_W-1:0] per_o,
  output logic             per_vld_o,
  output logic             ovf_o
);

  localparam logic [PER_W-1:0] LIM = PER_W'(OVF_LIM);

  logic             wave_q;
  logic             primed;
  logic [PER_W-1:0] cnt;
  logic             rise;

  assign rise = wave_i & ~wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q    <= 1'b0;
      primed    <= 1'b0;
      cnt       <= '0;
      per_o     <= '0;
      per_vld_o <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      wave_q    <= wave_i;
      per_vld_o <= 1'b0;
      ovf_o     <= 1'b0;
      if (rise) begin
        // a period is only complete if an earlier edge opened it
        per_o     <= cnt;
        per_vld_o <= primed;
        primed    <= 1'b1;
        cnt       <= PER_W'(1);
      end else if (cnt >= LIM) begin
        ovf_o  <= 1'b1;
        primed <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dtmf_period_avg.sv
module dtmf_period_avg #(
  parameter int PER_W = 13,
  parameter int AVG_N = 4,
  localparam int SUM_W  = PER_W + $clog2(AVG_N),
  localparam int FILL_W = $clog2(AVG_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] per_i,
  input  logic             per_vld_i,
  input  logic             clr_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             full_o
);

  localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(AVG_N);

  logic [PER_W-1:0]  hist [AVG_N];
  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int k = 0; k < AVG_N; k++) hist[k] <= '0;
      sum_o <= '0;
      fill  <= '0;
    end else if (per_vld_i) begin
      hist[0] <= per_i;
      for (int k = 1; k < AVG_N; k++) hist[k] <= hist[k-1];
      sum_o <= sum_o + SUM_W'(per_i) - SUM_W'(hist[AVG_N-1]);
      if (fill != FULL_CNT) fill <= fill + 1'b1;
    end
  end

  assign full_o = (fill == FULL_CNT);

endmodule

// File: rtl/dtmf_window_match.sv
module dtmf_window_match
  import dtmf_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter bit HI     = 1'b0,
  parameter int TOL_PM = 25,
  parameter int AVG_N  = 4,
  parameter int SUM_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] sum_i,
  input  logic             full_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [GRP_N-1:0] in_win;
  logic             hit;
  logic [IDX_W-1:0] idx;

  for (genvar k = 0; k < GRP_N; k++) begin : g_win
    localparam logic [SUM_W-1:0] W_LO =
      SUM_W'(win_lo(CLK_HZ, nom_hz(HI, k), TOL_PM, AVG_N));
    localparam logic [SUM_W-1:0] W_HI =
      SUM_W'(win_hi(CLK_HZ, nom_hz(HI, k), TOL_PM, AVG_N));
    assign in_win[k] = (sum_i >= W_LO) && (sum_i <= W_HI);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < GRP_N; k++) begin
      if (in_win[k] && !hit) begin
        hit = 1'b1;
        idx = k[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= full_i && hit;
      idx_o   <= (full_i && hit) ? idx : '0;
    end
  end

endmodule

// File: rtl/dtmf_tone_group.sv
module dtmf_tone_group
  import dtmf_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter bit HI     = 1'b0,
  parameter int TOL_PM = 25,
  parameter int AVG_N  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wave_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int OVF   = int'(ovf_cycles(CLK_HZ, HI, TOL_PM, AVG_N));
  localparam int PER_W = $clog2(OVF + 1);
  localparam int SUM_W = PER_W + $clog2(AVG_N);

  logic [PER_W-1:0] per;
  logic             per_vld;
  logic             ovf;
  logic [SUM_W-1:0] sum;
  logic             full;

  dtmf_period_meter #(.PER_W(PER_W), .OVF_LIM(OVF)) u_meter (
    .clk(clk), .rst(rst), .wave_i(wave_i),
    .per_o(per), .per_vld_o(per_vld), .ovf_o(ovf)
  );

  dtmf_period_avg #(.PER_W(PER_W), .AVG_N(AVG_N)) u_avg (
    .clk(clk), .rst(rst), .per_i(per), .per_vld_i(per_vld), .clr_i(ovf),
    .sum_o(sum), .full_o(full)
  );

  dtmf_window_match #(
    .CLK_HZ(CLK_HZ), .HI(HI), .TOL_PM(TOL_PM), .AVG_N(AVG_N), .SUM_W(SUM_W)
  ) u_match (
    .clk(clk), .rst(rst), .sum_i(sum), .full_i(full),
    .valid_o(valid_o), .idx_o(idx_o)
  );

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int TOL_PM = 25,
  parameter int AVG_N  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lo_wave,
  input  logic       hi_wave,
  output logic       row_valid,
  output logic       col_valid,
  output logic       pair_present,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);

  logic [1:0]       waves;
  logic [1:0]       grp_vld;
  logic [IDX_W-1:0] grp_idx [2];

  assign waves = {hi_wave, lo_wave};

  // band 0 = low group (rows), band 1 = high group (columns)
  for (genvar g = 0; g < 2; g++) begin : g_band
    dtmf_tone_group #(
      .CLK_HZ(CLK_HZ), .HI(g == 1), .TOL_PM(TOL_PM), .AVG_N(AVG_N)
    ) u_band (
      .clk(clk), .rst(rst), .wave_i(waves[g]),
      .valid_o(grp_vld[g]), .idx_o(grp_idx[g])
    );
  end

  assign row_valid    = grp_vld[0];
  assign col_valid    = grp_vld[1];
  assign row_idx      = grp_idx[0];
  assign col_idx      = grp_idx[1];
  assign pair_present = grp_vld[0] & grp_vld[1];

endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
module dtmf_pair_classifier_chk
  import dtmf_cls_pkg::*;
#(
  parameter int CLK_HZ = 3579545,
  parameter int TOL_PM = 25,
  parameter int AVG_N  = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       lo_wave,
  input logic       hi_wave,
  input logic       row_valid,
  input logic       col_valid,
  input logic       pair_present,
  input logic [1:0] row_idx,
  input logic [1:0] col_idx
);

  localparam int unsigned LIM_LO = int'(ovf_cycles(CLK_HZ, 1'b0, TOL_PM, AVG_N)) + 8;
  localparam int unsigned LIM_HI = int'(ovf_cycles(CLK_HZ, 1'b1, TOL_PM, AVG_N)) + 8;

  logic        lo_q, hi_q, rst_q;
  int unsigned quiet_lo, quiet_hi;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      lo_q     <= 1'b0;
      hi_q     <= 1'b0;
      quiet_lo <= 0;
      quiet_hi <= 0;
    end else begin
      lo_q <= lo_wave;
      hi_q <= hi_wave;
      if (lo_wave && !lo_q) quiet_lo <= 0;
      else if (quiet_lo <= LIM_LO) quiet_lo <= quiet_lo + 1;
      if (hi_wave && !hi_q) quiet_hi <= 0;
      else if (quiet_hi <= LIM_HI) quiet_hi <= quiet_hi + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_q == 1'b1) begin
      AST_RESET_CLEARS: assert (!row_valid && !col_valid && !pair_present); // R8
    end
  end

  AST_PAIR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    pair_present |-> (row_valid && col_valid)); // R6

  AST_ROW_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !row_valid |-> (row_idx == 2'd0)); // R9

  AST_COL_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !col_valid |-> (col_idx == 2'd0)); // R9

  AST_ROW_QUIET_DROP: assert property (@(posedge clk) disable iff (rst)
    (quiet_lo > LIM_LO) |-> !row_valid); // R7

  AST_COL_QUIET_DROP: assert property (@(posedge clk) disable iff (rst)
    (quiet_hi > LIM_HI) |-> !col_valid); // R7

endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk #(
  .CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .AVG_N(AVG_N)
) u_chk (
  .clk(clk), .rst(rst), .lo_wave(lo_wave), .hi_wave(hi_wave),
  .row_valid(row_valid), .col_valid(col_valid), .pair_present(pair_present),
  .row_idx(row_idx), .col_idx(col_idx)
);

// File: tb/test_dtmf_pair_classifier.sv
module test_dtmf_pair_classifier;

  localparam int TB_CLK_HZ = 400000;
  localparam int MAX_CYC   = 150000;

  // row, col, low offset (0.1 %), high offset (0.1 %), row accepted, col accepted
  localparam int VEC [8][6] = '{
    '{0, 0,   0,   0, 1, 1},
    '{1, 1,  14, -14, 1, 1},
    '{2, 2, -14,  14, 1, 1},
    '{3, 3,   0,   0, 1, 1},
    '{0, 3,  40,   0, 0, 1},
    '{2, 1,   0, -40, 1, 0},
    '{3, 0, -40,  40, 0, 0},
    '{1, 2,  14,  14, 1, 1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo_wave = 1'b0;
  logic       hi_wave = 1'b0;
  logic       row_valid, col_valid, pair_present;
  logic [1:0] row_idx, col_idx;

  int  checks = 0;
  int  errors = 0;
  real f_lo = 0.0, f_hi = 0.0, ph_lo = 0.0, ph_hi = 0.0;

  always #10 clk = ~clk;

  dtmf_pair_classifier #(.CLK_HZ(TB_CLK_HZ)) i_dtmf_pair_classifier (
    .clk(clk), .rst(rst), .lo_wave(lo_wave), .hi_wave(hi_wave),
    .row_valid(row_valid), .col_valid(col_valid), .pair_present(pair_present),
    .row_idx(row_idx), .col_idx(col_idx)
  );

  function automatic real tone_hz(input bit hi, input int k);
    real lo_t [4] = '{697.0, 770.0, 852.0, 941.0};
    real hi_t [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
    return hi ? hi_t[k] : lo_t[k];
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lo_wave = (f_lo > 0.0) && (ph_lo < 0.5);
      hi_wave = (f_hi > 0.0) && (ph_hi < 0.5);
      ph_lo = ph_lo + f_lo / TB_CLK_HZ;
      if (ph_lo >= 1.0) ph_lo = ph_lo - 1.0;
      ph_hi = ph_hi + f_hi / TB_CLK_HZ;
      if (ph_hi >= 1.0) ph_hi = ph_hi - 1.0;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(MAX_CYC * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state, R8
    run(5);
    chk("R8 row_valid in reset", row_valid, 0);
    chk("R8 col_valid in reset", col_valid, 0);
    chk("R8 pair_present in reset", pair_present, 0);
    chk("R9 row_idx in reset", row_idx, 0);
    chk("R9 col_idx in reset", col_idx, 0);
    rst = 1'b0;
    run(3);

    // vector table: accept / reject per band, mapping, pairing
    for (int v = 0; v < 8; v++) begin
      f_lo  = tone_hz(1'b0, VEC[v][0]) * (1.0 + VEC[v][2] / 1000.0);
      f_hi  = tone_hz(1'b1, VEC[v][1]) * (1.0 + VEC[v][3] / 1000.0);
      ph_lo = 0.0;
      ph_hi = 0.0;
      run(3500);
      chk(VEC[v][4] ? "R4 row accept" : "R5 row reject", row_valid, VEC[v][4]);
      chk(VEC[v][5] ? "R4 col accept" : "R5 col reject", col_valid, VEC[v][5]);
      chk("R2 row_idx", row_idx, VEC[v][4] ? VEC[v][0] : 0);
      chk("R3 col_idx", col_idx, VEC[v][5] ? VEC[v][1] : 0);
      chk("R6 pair_present", pair_present, VEC[v][4] & VEC[v][5]);
      f_lo = 0.0;
      f_hi = 0.0;
      run(1200);
      chk("R7 row drops on silence", row_valid, 0);
      chk("R7 col drops on silence", col_valid, 0);
      chk("R6 pair drops on silence", pair_present, 0);
    end

    // dropout of the high band while the low band keeps running
    f_lo = tone_hz(1'b0, 1); f_hi = tone_hz(1'b1, 2);
    ph_lo = 0.0; ph_hi = 0.0;
    run(3500);
    chk("R6 pair before dropout", pair_present, 1);
    f_hi = 0.0;
    run(700);
    chk("R7 col overflow", col_valid, 0);
    chk("R6 pair follows col loss", pair_present, 0);
    chk("R6 row unaffected", row_valid, 1);
    chk("R2 row_idx unaffected", row_idx, 1);
    chk("R9 col_idx idle", col_idx, 0);

    // reset in the middle of running tones
    f_hi = tone_hz(1'b1, 2); ph_hi = 0.0;
    run(3500);
    chk("R6 pair restored", pair_present, 1);
    rst = 1'b1;
    run(1);
    chk("R8 row cleared", row_valid, 0);
    chk("R8 col cleared", col_valid, 0);
    chk("R8 pair cleared", pair_present, 0);
    rst = 1'b0;
    run(1400);
    chk("R1 row needs four periods", row_valid, 0);
    run(2200);
    chk("R1 row after four periods", row_valid, 1);
    chk("R2 row_idx after reset", row_idx, 1);
    chk("R3 col_idx after reset", col_idx, 2);
    chk("R6 pair after reset", pair_present, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule